// File: doc/BRIEF.md
# Keyed Configuration Unlock Port

This unit sits on the host I/O bus of a legacy expansion card. The card stays silent until the host writes a fixed five-byte key. The first key byte goes to one fixed configuration port and the four that follow go to a second fixed port. The byte written to the second port straight after the key is a configuration word. It turns the card on or off, picks one of eight I/O base addresses and picks an interrupt line.

After a configuration word is taken, the unit locks itself again. Any change to the configuration needs the whole key once more. While the card is enabled it claims a 16-byte I/O window at the chosen base. A read outside a claimed window returns all ones, which is the value an empty bus gives. Inside the window the read data comes from the rest of the card. Two parameters pick the key set and the base-address table.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset, `cardEn` is 0, `baseAddr` is 0, `irqNum` is 0 and `winHit` is 0.
- R2: The key is accepted only in this order, with each byte written while `ioWrite` is high: key byte 0 to address 0x779, then key bytes 1 to 4 to address 0x379. The next write to 0x379 is then loaded as the configuration word. The outputs reflect it from the clock edge that samples that write.
- R3: Bit 7 of the configuration word is the enable and bits 2:0 are a base index. With the default table, index 0 to 7 selects 0x280, 0x290, 0x300, 0x310, 0x330, 0x340, 0x348 and 0x350, which is driven on `baseAddr` while enabled. Bit 3 is ignored.
- R4: Bits 6:4 of the configuration word are the interrupt code. Code 2 drives `irqNum` = 9. Any other code drives `irqNum` equal to the code, and code 0 means no interrupt.
- R5: A configuration word with bit 7 clear, including 0x00, disables the card: `cardEn` = 0, `baseAddr` = 0, `irqNum` = 0.
- R6: A write with the wrong byte, or to any address other than the one expected next, returns the matcher to idle. A configuration word written after an aborted key leaves the outputs unchanged.
- R7: A mismatching write of key byte 0 to 0x779 does not just abort. It restarts the match, so key bytes 1 to 4 and a word may follow directly.
- R8: After a configuration word is loaded, a further write to 0x379 leaves the outputs unchanged until a full key is written again.
- R9: `winHit` is 1 exactly when the card is enabled and `ioAddr` lies in [`baseAddr`, `baseAddr`+16). `rdData` equals `cardRdData` on a hit and 0xFF otherwise.
- R10: With KEY_SET=1 the key is 0x0F, 0x22, 0xF0, 0x20, 0x80, and the default key is not accepted. KEY_SET=0 selects the default key 0x59, 0xB9, 0xC5, 0xAE, 0xA6. With BASE_SET=1 the index table is 0x220, 0x240, 0x280, 0x2A0, 0x2C0, 0x300, 0x320, 0x340.
- R11: Address and data presented while `ioWrite` is low neither advance nor abort the key match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | ADDR_W | Host I/O address |
| ioData | input | 8 | Host write data |
| ioWrite | input | 1 | Write strobe, sampled on the rising edge |
| cardRdData | input | 8 | Read data from the rest of the card |
| cardEn | output | 1 | Card enabled |
| baseAddr | output | ADDR_W | Selected I/O base address, 0 when disabled |
| irqNum | output | 4 | Selected interrupt number, 0 for none |
| winHit | output | 1 | Address falls inside the claimed window |
| rdData | output | 8 | Read data seen by the host |

## Verification
The assertions assume that `ioWrite` is a single-cycle strobe whose address and data are stable at the sampling edge. They also assume that nothing but a strobed write moves the key matcher. The bench drives every write as one full clock cycle, set up on the falling edge, and drops `ioWrite` between writes. It changes address and data with the strobe low only where the R11 test wants to show that such bus activity is ignored. Outputs are sampled on the falling edge after the sampling edge.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  localparam int DATA_W  = 8;
  localparam int KEY_LEN = 5;

  typedef struct packed {
    logic       load;
    logic       en;
    logic [2:0] idx;
    logic [2:0] irqCode;
  } cfgStb_t;

  function automatic logic [7:0] keyByte(input int keySet, input int pos);
    logic [7:0] b;
    if (keySet == 1) begin
      case (pos)
        0: b = 8'h0F;
        1: b = 8'h22;
        2: b = 8'hF0;
        3: b = 8'h20;
        default: b = 8'h80;
      endcase
    end else begin
      case (pos)
        0: b = 8'h59;
        1: b = 8'hB9;
        2: b = 8'hC5;
        3: b = 8'hAE;
        default: b = 8'hA6;
      endcase
    end
    return b;
  endfunction

  function automatic logic [15:0] baseFor(input int baseSet, input logic [2:0] idx);
    logic [15:0] a;
    if (baseSet == 1) begin
      case (idx)
        3'd0: a = 16'h0220;
        3'd1: a = 16'h0240;
        3'd2: a = 16'h0280;
        3'd3: a = 16'h02A0;
        3'd4: a = 16'h02C0;
        3'd5: a = 16'h0300;
        3'd6: a = 16'h0320;
        default: a = 16'h0340;
      endcase
    end else begin
      case (idx)
        3'd0: a = 16'h0280;
        3'd1: a = 16'h0290;
        3'd2: a = 16'h0300;
        3'd3: a = 16'h0310;
        3'd4: a = 16'h0330;
        3'd5: a = 16'h0340;
        3'd6: a = 16'h0348;
        default: a = 16'h0350;
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/keyed_cfg_ctrl.sv
module keyed_cfg_ctrl
  import keyed_cfg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int KEY_SET    = 0,
  parameter logic [ADDR_W-1:0] FIRST_PORT = 'h779,
  parameter logic [ADDR_W-1:0] SEQ_PORT   = 'h379
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioWrite,
  output cfgStb_t           ctlStb
);

  localparam int STEP_W   = $clog2(KEY_LEN + 1);
  localparam logic [STEP_W-1:0] WORD_STEP = STEP_W'(KEY_LEN);

  logic [STEP_W-1:0] keyIdx;
  logic [STEP_W-1:0] keyIdxNxt;
  logic [DATA_W-1:0] expByte;
  logic [ADDR_W-1:0] expPort;
  logic              restartHit;

  always_comb begin
    expByte = keyByte(KEY_SET, int'(keyIdx));
    expPort = (keyIdx == '0) ? FIRST_PORT : SEQ_PORT;
    restartHit = (ioAddr == FIRST_PORT) && (ioData == keyByte(KEY_SET, 0));
  end

  always_comb begin
    keyIdxNxt      = keyIdx;
    ctlStb.load    = 1'b0;
    ctlStb.en      = ioData[7];
    ctlStb.idx     = ioData[2:0];
    ctlStb.irqCode = ioData[6:4];
    if (ioWrite) begin
      if (keyIdx == WORD_STEP && ioAddr == SEQ_PORT) begin
        ctlStb.load = 1'b1;
        keyIdxNxt   = '0;
      end else if (keyIdx != WORD_STEP && ioAddr == expPort && ioData == expByte) begin
        keyIdxNxt = keyIdx + 1'b1;
      end else if (restartHit) begin
        keyIdxNxt = STEP_W'(1);
      end else begin
        keyIdxNxt = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) keyIdx <= '0;
    else       keyIdx <= keyIdxNxt;
  end

  a_r6_foreign_port_idle: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrite && ioAddr != FIRST_PORT && ioAddr != SEQ_PORT) |=> keyIdx == '0);

  a_r11_no_strobe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ioWrite |=> $stable(keyIdx));

  a_r8_relock: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.load |=> keyIdx == '0);

  a_r7_restart_step: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrite && ioAddr == FIRST_PORT && ioData == keyByte(KEY_SET, 0)) |=> keyIdx == STEP_W'(1));

endmodule

// File: rtl/keyed_cfg_dp.sv
module keyed_cfg_dp
  import keyed_cfg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BASE_SET = 0,
  parameter int WIN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStb_t           ctlStb,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] cardRdData,
  output logic              cardEn,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [3:0]        irqNum,
  output logic              winHit,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W:0] WIN_SPAN = (ADDR_W+1)'(WIN_BYTES);
  localparam logic [2:0] IRQ9_CODE = 3'd2;

  logic       enReg;
  logic [2:0] idxReg;
  logic [2:0] irqReg;
  logic [ADDR_W:0] offs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      idxReg <= '0;
      irqReg <= '0;
    end else if (ctlStb.load) begin
      enReg  <= ctlStb.en;
      idxReg <= ctlStb.idx;
      irqReg <= ctlStb.irqCode;
    end
  end

  always_comb begin
    cardEn   = enReg;
    baseAddr = enReg ? ADDR_W'(baseFor(BASE_SET, idxReg)) : '0;
    if (!enReg)                  irqNum = 4'd0;
    else if (irqReg == IRQ9_CODE) irqNum = 4'd9;
    else                          irqNum = {1'b0, irqReg};
    offs   = {1'b0, ioAddr} - {1'b0, baseAddr};
    winHit = enReg && (ioAddr >= baseAddr) && (offs < WIN_SPAN);
    rdData = winHit ? cardRdData : '1;
  end

  a_r2_load_word: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.load |=> (cardEn == $past(ctlStb.en)));

  a_r8_hold_cfg: assert property (@(posedge clk) disable iff (!rstN)
    !ctlStb.load |=> ($stable(cardEn) && $stable(baseAddr) && $stable(irqNum)));

  a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cardEn |-> (baseAddr == '0 && irqNum == 4'd0 && !winHit));

  a_r9_float_read: assert property (@(posedge clk) disable iff (!rstN)
    !winHit |-> rdData == '1);

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int KEY_SET   = 0,
  parameter int BASE_SET  = 0,
  parameter int WIN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioData,
  input  logic              ioWrite,
  input  logic [7:0]        cardRdData,
  output logic              cardEn,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [3:0]        irqNum,
  output logic              winHit,
  output logic [7:0]        rdData
);

  cfgStb_t ctlStb;

  keyed_cfg_ctrl #(
    .ADDR_W (ADDR_W),
    .KEY_SET(KEY_SET)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ioAddr (ioAddr),
    .ioData (ioData),
    .ioWrite(ioWrite),
    .ctlStb (ctlStb)
  );

  keyed_cfg_dp #(
    .ADDR_W   (ADDR_W),
    .BASE_SET (BASE_SET),
    .WIN_BYTES(WIN_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctlStb    (ctlStb),
    .ioAddr    (ioAddr),
    .cardRdData(cardRdData),
    .cardEn    (cardEn),
    .baseAddr  (baseAddr),
    .irqNum    (irqNum),
    .winHit    (winHit),
    .rdData    (rdData)
  );

endmodule

// File: tb/sim_keyed_cfg_port.sv
module sim_keyed_cfg_port;

  localparam logic [15:0] P_FIRST = 16'h0779;
  localparam logic [15:0] P_SEQ   = 16'h0379;
  localparam logic [7:0] KEYA [0:4] = '{8'h59, 8'hB9, 8'hC5, 8'hAE, 8'hA6};
  localparam logic [7:0] KEYB [0:4] = '{8'h0F, 8'h22, 8'hF0, 8'h20, 8'h80};
  // word[28:21] en[20] base[19:4] irq[3:0]
  localparam logic [28:0] VEC [0:7] = '{
    {8'h80, 1'b1, 16'h0280, 4'd0},
    {8'h93, 1'b1, 16'h0310, 4'd1},
    {8'hA5, 1'b1, 16'h0340, 4'd9},
    {8'hF7, 1'b1, 16'h0350, 4'd7},
    {8'hBE, 1'b1, 16'h0348, 4'd3},
    {8'h00, 1'b0, 16'h0000, 4'd0},
    {8'hC4, 1'b1, 16'h0330, 4'd4},
    {8'h7F, 1'b0, 16'h0000, 4'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioData = '0;
  logic        ioWrite = 1'b0;
  logic [7:0]  cardRdData = 8'h5A;
  logic        en0, en1, hit0, hit1;
  logic [15:0] base0, base1;
  logic [3:0]  irq0, irq1;
  logic [7:0]  rd0, rd1;
  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  keyed_cfg_port u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioData(ioData), .ioWrite(ioWrite),
    .cardRdData(cardRdData), .cardEn(en0), .baseAddr(base0), .irqNum(irq0),
    .winHit(hit0), .rdData(rd0)
  );

  keyed_cfg_port #(.KEY_SET(1), .BASE_SET(1)) u1 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioData(ioData), .ioWrite(ioWrite),
    .cardRdData(cardRdData), .cardEn(en1), .baseAddr(base1), .irqNum(irq1),
    .winHit(hit1), .rdData(rd1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioData = d; ioWrite = 1'b1;
    @(negedge clk);
    ioWrite = 1'b0;
  endtask

  task automatic unlockA(input logic [7:0] word);
    for (int i = 0; i < 5; i++) wr(i == 0 ? P_FIRST : P_SEQ, KEYA[i]);
    wr(P_SEQ, word);
  endtask

  task automatic checkOut0(input string req, input logic en, input logic [15:0] b, input logic [3:0] q);
    check(req, {31'd0, en0}, {31'd0, en});
    check(req, {16'd0, base0}, {16'd0, b});
    check(req, {28'd0, irq0}, {28'd0, q});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkOut0("R1", 1'b0, 16'h0, 4'd0);
    check("R1", {31'd0, hit0}, 32'd0);
    check("R9", {24'd0, rd0}, 32'hFF);

    // R2 R3 R4 R5 vector walk
    for (int v = 0; v < 8; v++) begin
      unlockA(VEC[v][28:21]);
      checkOut0("R2/R3/R4/R5", VEC[v][20], VEC[v][19:4], VEC[v][3:0]);
    end
    // R10 default key not taken by alternate set
    check("R10", {31'd0, en1}, 32'd0);

    // configure 0x310, irq 1
    unlockA(8'h93);
    checkOut0("R2", 1'b1, 16'h0310, 4'd1);

    // R9 window
    @(negedge clk); ioAddr = 16'h0310;
    #1 check("R9", {31'd0, hit0}, 32'd1);
    check("R9", {24'd0, rd0}, 32'h5A);
    ioAddr = 16'h031F;
    #1 check("R9", {31'd0, hit0}, 32'd1);
    ioAddr = 16'h0320;
    #1 check("R9", {31'd0, hit0}, 32'd0);
    check("R9", {24'd0, rd0}, 32'hFF);
    ioAddr = 16'h030F;
    #1 check("R9", {24'd0, rd0}, 32'hFF);

    // R8 relock: extra word ignored
    wr(P_SEQ, 8'hF7);
    checkOut0("R8", 1'b1, 16'h0310, 4'd1);

    // R6 wrong byte aborts
    wr(P_FIRST, KEYA[0]); wr(P_SEQ, KEYA[1]); wr(P_SEQ, 8'h00);
    wr(P_SEQ, KEYA[2]); wr(P_SEQ, KEYA[3]); wr(P_SEQ, KEYA[4]); wr(P_SEQ, 8'h80);
    checkOut0("R6", 1'b1, 16'h0310, 4'd1);
    // R6 wrong port aborts
    wr(P_FIRST, KEYA[0]); wr(P_SEQ, KEYA[1]); wr(16'h037A, KEYA[2]);
    wr(P_SEQ, KEYA[3]); wr(P_SEQ, KEYA[4]); wr(P_SEQ, 8'h80);
    checkOut0("R6", 1'b1, 16'h0310, 4'd1);

    // R7 restart on first key byte
    wr(P_FIRST, KEYA[0]); wr(P_SEQ, KEYA[1]); wr(P_FIRST, KEYA[0]);
    for (int i = 1; i < 5; i++) wr(P_SEQ, KEYA[i]);
    wr(P_SEQ, 8'hA1);
    checkOut0("R7", 1'b1, 16'h0290, 4'd9);

    // R11 bus activity without strobe ignored
    wr(P_FIRST, KEYA[0]); wr(P_SEQ, KEYA[1]);
    @(negedge clk); ioAddr = 16'h0123; ioData = 8'h00;
    @(negedge clk);
    wr(P_SEQ, KEYA[2]); wr(P_SEQ, KEYA[3]); wr(P_SEQ, KEYA[4]); wr(P_SEQ, 8'hC6);
    checkOut0("R11", 1'b1, 16'h0348, 4'd4);

    // R10 alternate key and table on u1
    for (int i = 0; i < 5; i++) wr(i == 0 ? P_FIRST : P_SEQ, KEYB[i]);
    wr(P_SEQ, 8'hD1);
    check("R10", {31'd0, en1}, 32'd1);
    check("R10", {16'd0, base1}, 32'h0240);
    check("R10", {28'd0, irq1}, 32'd5);
    checkOut0("R10", 1'b1, 16'h0348, 4'd4);

    // R5 disable and float read
    unlockA(8'h00);
    checkOut0("R5", 1'b0, 16'h0, 4'd0);
    @(negedge clk); ioAddr = 16'h0348;
    #1 check("R9", {24'd0, rd0}, 32'hFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule